// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block performs hardware flow control for one serial channel. On the receive side it watches how full the local receive FIFO is. It drives the active-low request-to-send line high to ask the far end to pause once the fill reaches the programmed trigger level. It drives the line low again after the fill has drained past a release point. The release point sits below the trigger by a selectable hysteresis gap, so the line does not toggle on every byte. When automatic RTS is switched off, the line simply follows a software request bit.

On the transmit side it samples the active-low clear-to-send input and produces a transmit-permit signal for the serial shifter. The permit is re-decided only when the shifter reports a character boundary, so a character that has already started is always finished. Changes of either line made under automatic control raise a sticky modem-status event, which is visible on the interrupt output when enabled and is cleared by an acknowledge pulse.

There is no data stream through this block. Every pin is a plain level or strobe, and there is no valid/ready handshake and no back-pressure.

Top module: `afc_flow_ctrl`

## Requirements
- R1: During reset, rts_n is 1, tx_permit is 1 and msr_irq is 0.
- R2: With auto_rts_en=1, a clock edge at which rx_fill >= rx_trig makes rts_n 1 from that edge on.
- R3: With hyst_sel=0 the release point is rx_trig-1. A clock edge at which rx_fill is below rx_trig makes rts_n 0.
- R4: With hyst_sel=1, 2 or 3 the release point is rx_trig minus 4, 8 or 16, floored at 0. rts_n goes to 0 at an edge where rx_fill <= release point. For fills strictly between the release point and the trigger, rts_n keeps its previous value.
- R5: With auto_rts_en=0, rts_n after each edge equals the inverse of rts_sw_req sampled at that edge.
- R6: With auto_cts_en=1, tx_permit changes only at an edge where char_done=1, and it then becomes the inverse of cts_n. A change of cts_n while char_done=0 has no effect on tx_permit.
- R7: With auto_cts_en=0, tx_permit is 1 after every edge.
- R8: A pending event is set at an edge where rts_n changes while auto_rts_en=1, or where cts_n differs from its value at the previous edge while auto_cts_en=1. An edge with msr_irq_ack=1 and no new event clears it. msr_irq is the pending event ANDed with msr_irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_fill | input | FILL_W (7) | Current receive FIFO fill count |
| rx_trig | input | FILL_W (7) | Programmed receive trigger level |
| hyst_sel | input | 2 | Hysteresis select: 0 gap 1, 1 gap 4, 2 gap 8, 3 gap 16 |
| auto_rts_en | input | 1 | Enable automatic RTS control |
| auto_cts_en | input | 1 | Enable automatic CTS gating |
| rts_sw_req | input | 1 | Software RTS request (1 drives rts_n low) when automatic RTS is off |
| cts_n | input | 1 | Active-low clear-to-send from the far end |
| char_done | input | 1 | Transmitter character-boundary strobe |
| msr_irq_en | input | 1 | Modem-status interrupt enable |
| msr_irq_ack | input | 1 | Clears the pending modem-status event |
| rts_n | output | 1 | Active-low request-to-send to the far end |
| tx_permit | output | 1 | Transmitter may start the next character |
| msr_irq | output | 1 | Modem-status interrupt request |

## Verification
The fill level is first swept up through the trigger and back down to zero for each hysteresis code. This separates the four release points and shows that the line holds its state inside the hysteresis band. A trigger of 6 with the widest gap shows the floor at zero. A long random walk of the fill, with random trigger and hysteresis changes, then exercises mode switches that the directed sweeps miss. Clear-to-send is toggled both with and without boundary strobes, which separates boundary-gated behaviour from plain level following. Random acknowledge and enable pulses, some landing on the same edge as a new event, check that a new event wins over an acknowledge on that edge.

// File: rtl/afc_pkg.sv
package afc_pkg;
  typedef enum logic [1:0] {
    HYST_NEXT  = 2'd0,
    HYST_GAP1  = 2'd1,
    HYST_GAP2  = 2'd2,
    HYST_GAP3  = 2'd3
  } hyst_e;
endpackage

// File: rtl/afc_rts_hyst.sv
module afc_rts_hyst
  import afc_pkg::*;
#(
  parameter int FILL_W    = 7,
  parameter int HYST_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [FILL_W-1:0] rx_trig,
  input  logic [1:0]        hyst_sel,
  input  logic              auto_en,
  input  logic              sw_req,
  output logic              rts_n,
  output logic              rts_evt
);
  logic [FILL_W-1:0] gap;
  logic [FILL_W-1:0] release_pt;
  logic              pause_q, pause_d;
  logic              rts_n_d;

  always_comb begin
    case (hyst_e'(hyst_sel))
      HYST_NEXT: gap = FILL_W'(1);
      HYST_GAP1: gap = FILL_W'(HYST_STEP);
      HYST_GAP2: gap = FILL_W'(HYST_STEP * 2);
      default:   gap = FILL_W'(HYST_STEP * 4);
    endcase
    release_pt = (rx_trig > gap) ? (rx_trig - gap) : '0;
  end

  // Trigger wins over release when both hold (trigger of zero).
  always_comb begin
    if (rx_fill >= rx_trig)
      pause_d = 1'b1;
    else if (rx_fill <= release_pt)
      pause_d = 1'b0;
    else
      pause_d = pause_q;
    rts_n_d = auto_en ? pause_d : ~sw_req;
  end

  assign rts_evt = auto_en & (rts_n_d != rts_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_q <= 1'b0;
      rts_n   <= 1'b1;
    end else begin
      pause_q <= pause_d;
      rts_n   <= rts_n_d;
    end
  end
endmodule

// File: rtl/afc_cts_gate.sv
module afc_cts_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  input  logic auto_en,
  input  logic char_done,
  output logic tx_permit,
  output logic cts_evt
);
  logic cts_q;

  assign cts_evt = auto_en & (cts_n != cts_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_q     <= 1'b1;
      tx_permit <= 1'b1;
    end else begin
      cts_q <= cts_n;
      if (!auto_en)
        tx_permit <= 1'b1;
      else if (char_done)
        tx_permit <= ~cts_n;
    end
  end
endmodule

// File: rtl/afc_event_irq.sv
module afc_event_irq #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_evt,
  input  logic             irq_en,
  input  logic             irq_ack,
  output logic             irq
);
  logic pend_q;
  logic any_evt;

  assign any_evt = |src_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= 1'b0;
    else if (any_evt)
      pend_q <= 1'b1;
    else if (irq_ack)
      pend_q <= 1'b0;
  end

  assign irq = pend_q & irq_en;
endmodule

// File: rtl/afc_flow_ctrl.sv
module afc_flow_ctrl #(
  parameter int FIFO_DEPTH = 64,
  parameter int HYST_STEP  = 4,
  localparam int FILL_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [FILL_W-1:0] rx_trig,
  input  logic [1:0]        hyst_sel,
  input  logic              auto_rts_en,
  input  logic              auto_cts_en,
  input  logic              rts_sw_req,
  input  logic              cts_n,
  input  logic              char_done,
  input  logic              msr_irq_en,
  input  logic              msr_irq_ack,
  output logic              rts_n,
  output logic              tx_permit,
  output logic              msr_irq
);
  logic rts_evt, cts_evt;

  afc_rts_hyst #(.FILL_W(FILL_W), .HYST_STEP(HYST_STEP)) rts_i (
    .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .rx_trig(rx_trig),
    .hyst_sel(hyst_sel), .auto_en(auto_rts_en), .sw_req(rts_sw_req),
    .rts_n(rts_n), .rts_evt(rts_evt)
  );

  afc_cts_gate cts_i (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .auto_en(auto_cts_en),
    .char_done(char_done), .tx_permit(tx_permit), .cts_evt(cts_evt)
  );

  afc_event_irq #(.N_SRC(2)) irq_i (
    .clk(clk), .rst_n(rst_n), .src_evt({cts_evt, rts_evt}),
    .irq_en(msr_irq_en), .irq_ack(msr_irq_ack), .irq(msr_irq)
  );
endmodule

// File: rtl/afc_flow_ctrl_chk.sv
module afc_flow_ctrl_chk #(
  parameter int FILL_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FILL_W-1:0] rx_fill,
  input logic [FILL_W-1:0] rx_trig,
  input logic              auto_rts_en,
  input logic              auto_cts_en,
  input logic              rts_sw_req,
  input logic              char_done,
  input logic              msr_irq_en,
  input logic              rts_n,
  input logic              tx_permit,
  input logic              msr_irq
);
  AST_RTS_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    auto_rts_en && (rx_fill >= rx_trig) |=> rts_n); // R2
  AST_RTS_EMPTY_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    auto_rts_en && (rx_fill == '0) && (rx_trig != '0) |=> !rts_n); // R4
  AST_RTS_SOFTWARE: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |=> (rts_n == !$past(rts_sw_req))); // R5
  AST_PERMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    auto_cts_en && !char_done |=> $stable(tx_permit)); // R6
  AST_PERMIT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_cts_en |=> tx_permit); // R7
  AST_IRQ_ON_RTS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(auto_rts_en) && (rts_n != $past(rts_n)) && msr_irq_en |-> msr_irq); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !msr_irq_en |-> !msr_irq); // R8
endmodule

bind afc_flow_ctrl afc_flow_ctrl_chk #(.FILL_W(FILL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .rx_trig(rx_trig),
  .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
  .rts_sw_req(rts_sw_req), .char_done(char_done), .msr_irq_en(msr_irq_en),
  .rts_n(rts_n), .tx_permit(tx_permit), .msr_irq(msr_irq)
);

// File: tb/afc_flow_ctrl_tb_top.sv
module afc_flow_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FILL_W     = 7;
  localparam int WATCHDOG   = 100000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [FILL_W-1:0] rx_fill = '0;
  logic [FILL_W-1:0] rx_trig = 7'd16;
  logic [1:0]        hyst_sel = 2'd0;
  logic              auto_rts_en = 1'b0, auto_cts_en = 1'b0, rts_sw_req = 1'b0;
  logic              cts_n = 1'b1, char_done = 1'b0;
  logic              msr_irq_en = 1'b0, msr_irq_ack = 1'b0;
  logic              rts_n, tx_permit, msr_irq;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    cmp_on = 1'b0;
  string tag = "R1";

  // reference model state
  bit m_paused, m_rts, m_permit, m_pend, m_cts_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  afc_flow_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .rx_trig(rx_trig),
    .hyst_sel(hyst_sel), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
    .rts_sw_req(rts_sw_req), .cts_n(cts_n), .char_done(char_done),
    .msr_irq_en(msr_irq_en), .msr_irq_ack(msr_irq_ack),
    .rts_n(rts_n), .tx_permit(tx_permit), .msr_irq(msr_irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_paused = 0; m_rts = 1; m_permit = 1; m_pend = 0; m_cts_q = 1;
    end else begin
      int gap, rel, fill, trig;
      bit nrts, evt;
      fill = int'(rx_fill);
      trig = int'(rx_trig);
      gap  = (hyst_sel == 0) ? 1 : (4 << (hyst_sel - 1));
      rel  = (trig > gap) ? trig - gap : 0;
      if (fill >= trig)     m_paused = 1;
      else if (fill <= rel) m_paused = 0;
      nrts = auto_rts_en ? m_paused : !rts_sw_req;
      evt  = (auto_rts_en && nrts != m_rts) || (auto_cts_en && cts_n != m_cts_q);
      if (evt) m_pend = 1;
      else if (msr_irq_ack) m_pend = 0;
      m_rts = nrts;
      if (!auto_cts_en) m_permit = 1;
      else if (char_done) m_permit = !cts_n;
      m_cts_q = cts_n;
    end
  end

  task automatic check(string req, string what, bit act, bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check(tag, "rts_n", rts_n, m_rts);
      check(tag, "tx_permit", tx_permit, m_permit);
      check("R8", "msr_irq", msr_irq, m_pend & msr_irq_en);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic sweep(int top, int lo);
    for (int f = 0; f <= top; f++) begin rx_fill = 7'(f); tick(); end
    for (int f = top; f >= lo; f--) begin rx_fill = 7'(f); tick(); end
  endtask

  initial begin
    tick(3);
    check("R1", "rts_n reset", rts_n, 1'b1);
    check("R1", "tx_permit reset", tx_permit, 1'b1);
    check("R1", "msr_irq reset", msr_irq, 1'b0);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // software RTS
    tag = "R5";
    rts_sw_req = 1'b1; tick();
    check("R5", "rts_n follows sw", rts_n, 1'b0);
    rts_sw_req = 1'b0; tick();
    check("R5", "rts_n follows sw", rts_n, 1'b1);
    rx_fill = 7'd40; tick(2);
    check("R5", "fill ignored", rts_n, 1'b1);

    // auto RTS, hysteresis code 0
    tag = "R3";
    rx_fill = '0; auto_rts_en = 1'b1; rx_trig = 7'd16; hyst_sel = 2'd0; tick();
    rx_fill = 7'd16; tick();
    check("R2", "pause at trigger", rts_n, 1'b1);
    rx_fill = 7'd15; tick();
    check("R3", "resume below trigger", rts_n, 1'b0);
    sweep(20, 0);

    // hysteresis codes 1..3
    tag = "R4";
    rx_trig = 7'd32;
    for (int h = 1; h <= 3; h++) begin
      int rel;
      hyst_sel = 2'(h);
      rel = 32 - (4 << (h - 1));
      rx_fill = 7'd33; tick();
      check("R2", "pause above trigger", rts_n, 1'b1);
      rx_fill = 7'(rel + 1); tick();
      check("R4", "hold inside band", rts_n, 1'b1);
      rx_fill = 7'(rel); tick();
      check("R4", "release at point", rts_n, 1'b0);
      rx_fill = 7'(rel + 2); tick();
      check("R4", "stay resumed in band", rts_n, 1'b0);
      sweep(40, 0);
    end
    rx_trig = 7'd6; hyst_sel = 2'd3;
    rx_fill = 7'd6; tick();
    rx_fill = 7'd1; tick();
    check("R4", "floor hold at 1", rts_n, 1'b1);
    rx_fill = 7'd0; tick();
    check("R4", "floor release at 0", rts_n, 1'b0);

    // CTS gating
    tag = "R6";
    auto_cts_en = 1'b1; cts_n = 1'b0; char_done = 1'b1; tick();
    char_done = 1'b0;
    check("R6", "permit with cts low", tx_permit, 1'b1);
    cts_n = 1'b1; tick(5);
    check("R6", "mid-character cts ignored", tx_permit, 1'b1);
    char_done = 1'b1; tick(); char_done = 1'b0;
    check("R6", "stop at boundary", tx_permit, 1'b0);
    cts_n = 1'b0; tick(3);
    check("R6", "no resume before boundary", tx_permit, 1'b0);
    char_done = 1'b1; tick(); char_done = 1'b0;
    check("R6", "resume at boundary", tx_permit, 1'b1);
    tag = "R7";
    cts_n = 1'b1; char_done = 1'b1; tick(); char_done = 1'b0;
    auto_cts_en = 1'b0; tick();
    check("R7", "permit free when off", tx_permit, 1'b1);

    // interrupt
    msr_irq_en = 1'b1; msr_irq_ack = 1'b1; tick(); msr_irq_ack = 1'b0;
    check("R8", "cleared by ack", msr_irq, 1'b0);
    rx_trig = 7'd10; hyst_sel = 2'd0; rx_fill = 7'd12; tick();
    check("R8", "irq on rts change", msr_irq, 1'b1);
    msr_irq_en = 1'b0; #1;
    check("R8", "irq masked", msr_irq, 1'b0);
    msr_irq_en = 1'b1; msr_irq_ack = 1'b1; rx_fill = 7'd0; tick(); msr_irq_ack = 1'b0;
    check("R8", "new event beats ack", msr_irq, 1'b1);

    // random walk
    tag = "R4";
    for (int i = 0; i < 6000; i++) begin
      int f;
      f = int'(rx_fill) + $urandom_range(0, 6) - 3;
      if (f < 0) f = 0;
      if (f > 64) f = 64;
      rx_fill = 7'(f);
      if ($urandom_range(0, 99) == 0) rx_trig = 7'($urandom_range(0, 60));
      if ($urandom_range(0, 99) == 0) hyst_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 199) == 0) auto_rts_en = ~auto_rts_en;
      if ($urandom_range(0, 199) == 0) auto_cts_en = ~auto_cts_en;
      rts_sw_req  = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 15) == 0) cts_n = ~cts_n;
      char_done   = ($urandom_range(0, 9) == 0);
      msr_irq_ack = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 49) == 0) msr_irq_en = ~msr_irq_en;
      tick();
    end
    cmp_on = 1'b0;
    summary();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule